// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

Two independent timer/counter units, each made of a high byte and a low byte, share one mode register and one control register. A unit advances on a qualified count event. That event is either an internal machine-cycle tick or a falling edge on the unit's external count pin. The unit's run bit enables it, and its gate pin can qualify it as well. Each unit has four modes: a 13-bit counter whose low byte acts as a 5-bit prescaler, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode, unit 0 becomes two 8-bit counters. One of them takes over unit 1's run bit and overflow flag. Unit 1 halts if it is placed in that mode itself.

Software loads and reads every register one byte at a time through a select code. Each unit raises an overflow flag that is held until one of three things happens: an acknowledge pulse clears it, a control-register write changes it, or a new overflow sets it again. The flags go straight to an interrupt controller outside this block.

Top module: `dual_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero and both overflow flags are low.
- R2: Select codes are 0 mode, 1 control, 2 unit-0 low, 3 unit-0 high, 4 unit-1 low, 5 unit-1 high; codes 6 and 7 read zero and writes to them do nothing. The mode register holds unit 0 in bits 3:0 and unit 1 in bits 7:4, each nibble as {gate, external select, mode[1:0]}. Control bit 7 is unit-1 flag, bit 6 unit-1 run, bit 5 unit-0 flag, bit 4 unit-0 run; bits 3:0 read zero and ignore writes.
- R3: Mode 01 counts the high:low pair as one 16-bit value; stepping from FFFF to 0000 sets the unit's flag.
- R4: Mode 00 counts bits 4:0 of the low byte as a prescaler; when they wrap from 1F the high byte increments; bits 7:5 of the low byte keep their value; the flag sets when the high byte wraps at that moment.
- R5: Mode 10 increments the low byte; an event with the low byte at FF loads it from the high byte and sets the flag.
- R6: In unit-0 mode 11, unit-0 low byte counts under unit-0 controls and sets flag 0 on wrap; unit-0 high byte counts internal ticks while unit-1 run is set (no gate) and sets flag 1 on wrap; unit-1 overflows then leave flag 1 alone.
- R7: Unit 1 in mode 11 holds both its bytes.
- R8: With gate set a unit counts only while its gate pin is high and its run bit is set; with gate clear the run bit alone enables it.
- R9: With external select set, a unit counts a tick at which the count pin is low after having been high at the previous tick; with it clear every tick counts.
- R10: A flag clears on an acknowledge pulse or by a control write of zero, a control write of one sets it, and an overflow in the same cycle wins over both.
- R11: A byte write in the same cycle as a count event takes the written value for that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle tick enable |
| cnt_pin | input | 2 | External count pin per unit |
| gate_pin | input | 2 | Gate (external interrupt) pin per unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 8 | Read data (combinational) |
| ovf_ack | input | 2 | Per-unit overflow flag clear |
| ovf_flag | output | 2 | Per-unit overflow flag |

## Verification
Each mode is run from preloaded values placed just below the wrap point. This shows whether the carry is taken from the right width (5, 8, 13 or 16 bits) and whether the reload or prescaler bits are kept. Ticks arrive every cycle in some runs and every second or third cycle in others, with the count pin toggling. This distinguishes counting on every tick from counting on falling edges alone, and shows whether gating comes from the pin or from the run bit. Split mode runs with unit 1 about to wrap at the same time. This shows whether flag 1 follows unit 0's high byte or unit 1. Collisions of an acknowledge, a control write or a byte write with an overflow show which source takes priority.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int BYTE_W  = 8;
    localparam int PRESC_W = 5;
    localparam int SEL_W   = 3;
    localparam int UNITS   = 2;

    typedef enum logic [1:0] {
        M_PRESC13 = 2'b00,
        M_CASC16  = 2'b01,
        M_RELOAD8 = 2'b10,
        M_SPLIT   = 2'b11
    } tc_mode_e;

    typedef struct packed {
        logic     gate;
        logic     ext;
        tc_mode_e mode;
    } tc_cfg_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_LO0  = 3'd2,
        SEL_HI0  = 3'd3,
        SEL_LO1  = 3'd4,
        SEL_HI1  = 3'd5
    } tc_sel_e;

    function automatic tc_cfg_t nib_to_cfg(input logic [3:0] nib);
        return tc_cfg_t'(nib);
    endfunction
endpackage

// File: rtl/tcp_event.sv
module tcp_event (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    input  logic gate_pin,
    input  logic run,
    input  logic gate,
    input  logic ext,
    output logic evt
);
    logic pin_prev;
    logic enabled;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst)       pin_prev <= 1'b0;
        else if (tick) pin_prev <= pin;
    end

    assign enabled = run & (~gate | gate_pin);
    assign fall    = pin_prev & ~pin;
    assign evt     = tick & enabled & (ext ? fall : 1'b1);
endmodule

// File: rtl/tcp_core.sv
module tcp_core
    import tcp_pkg::*;
#(
    parameter int W        = BYTE_W,
    parameter int PW       = PRESC_W,
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_lo,
    input  logic         inc_hi,
    input  tc_mode_e     mode,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic         ovf_main,
    output logic         ovf_split
);
    localparam int DW = 2 * W;

    logic [W-1:0] lo_n, hi_n;
    logic         split_act;

    assign split_act = SPLIT_OK && (mode == M_SPLIT);

    always_comb begin
        lo_n      = lo_q;
        hi_n      = hi_q;
        ovf_main  = 1'b0;
        ovf_split = 1'b0;
        if (inc_lo) begin
            unique case (mode)
                M_PRESC13: begin
                    if (lo_q[PW-1:0] == '1) begin
                        hi_n     = hi_q + 1'b1;
                        ovf_main = (hi_q == '1);
                    end
                    lo_n[PW-1:0] = lo_q[PW-1:0] + 1'b1;
                end
                M_CASC16: begin
                    {hi_n, lo_n} = DW'({hi_q, lo_q} + 1'b1);
                    ovf_main     = ({hi_q, lo_q} == '1);
                end
                M_RELOAD8: begin
                    if (lo_q == '1) begin
                        lo_n     = hi_q;
                        ovf_main = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
                M_SPLIT: begin
                    if (SPLIT_OK) begin
                        lo_n     = lo_q + 1'b1;
                        ovf_main = (lo_q == '1);
                    end
                end
                default: ;
            endcase
        end
        if (split_act && inc_hi) begin
            hi_n      = hi_q + 1'b1;
            ovf_split = (hi_q == '1);
        end
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // R5: reload takes the high byte
    a_r5_reload_from_high: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RELOAD8 && inc_lo && lo_q == '1 && !wr_lo) |=> (lo_q == $past(hi_q)));

    // R7: a unit without split capability halts in mode 11
    a_r7_halted: assert property (@(posedge clk) disable iff (rst)
        (!SPLIT_OK && mode == M_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R11: byte write wins over counting
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (hi_q == $past(wr_data)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import tcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [UNITS-1:0]  cnt_pin,
    input  logic [UNITS-1:0]  gate_pin,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [UNITS-1:0]  ovf_ack,
    output logic [UNITS-1:0]  ovf_flag
);
    localparam int RUN_BIT0  = 4;
    localparam int FLAG_BIT0 = 5;
    localparam int UNIT_STEP = 2;

    logic [BYTE_W-1:0] mode_q;
    logic [UNITS-1:0]  run_q, flag_q, flag_n, set_hw;
    logic [UNITS-1:0]  evt, ovf_main, ovf_split;
    logic [BYTE_W-1:0] lo_q [UNITS];
    logic [BYTE_W-1:0] hi_q [UNITS];
    tc_cfg_t           cfg  [UNITS];
    logic              split_on, ctrl_wr;

    assign split_on = (cfg[0].mode == M_SPLIT);
    assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        assign cfg[u] = nib_to_cfg(mode_q[4*u +: 4]);

        tcp_event u_evt (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .pin      (cnt_pin[u]),
            .gate_pin (gate_pin[u]),
            .run      (run_q[u]),
            .gate     (cfg[u].gate),
            .ext      (cfg[u].ext),
            .evt      (evt[u])
        );

        tcp_core #(.W(BYTE_W), .PW(PRESC_W), .SPLIT_OK(u == 0)) u_core (
            .clk       (clk),
            .rst       (rst),
            .inc_lo    (evt[u]),
            .inc_hi    ((u == 0) ? (tick & run_q[UNITS-1] & split_on) : 1'b0),
            .mode      (cfg[u].mode),
            .wr_lo     (wr_en && (wr_sel == SEL_W'(SEL_LO0 + UNIT_STEP * u))),
            .wr_hi     (wr_en && (wr_sel == SEL_W'(SEL_HI0 + UNIT_STEP * u))),
            .wr_data   (wr_data),
            .lo_q      (lo_q[u]),
            .hi_q      (hi_q[u]),
            .ovf_main  (ovf_main[u]),
            .ovf_split (ovf_split[u])
        );

        always_comb begin
            flag_n[u] = ctrl_wr ? wr_data[FLAG_BIT0 + UNIT_STEP * u]
                                : (flag_q[u] & ~ovf_ack[u]);
            flag_n[u] = flag_n[u] | set_hw[u];
        end
    end

    assign set_hw[0] = ovf_main[0];
    assign set_hw[1] = split_on ? ovf_split[0] : ovf_main[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_MODE) mode_q <= wr_data;
            if (ctrl_wr) run_q <= {wr_data[RUN_BIT0 + UNIT_STEP], wr_data[RUN_BIT0]};
            flag_q <= flag_n;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_MODE: rd_data = mode_q;
            SEL_CTRL: rd_data = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
            SEL_LO0:  rd_data = lo_q[0];
            SEL_HI0:  rd_data = hi_q[0];
            SEL_LO1:  rd_data = lo_q[1];
            SEL_HI1:  rd_data = hi_q[1];
            default:  rd_data = '0;
        endcase
    end

    assign ovf_flag = flag_q;

    // R10: a hardware overflow always leaves the flag set
    a_r10_hw_set_wins0: assert property (@(posedge clk) disable iff (rst)
        set_hw[0] |=> ovf_flag[0]);
    a_r10_hw_set_wins1: assert property (@(posedge clk) disable iff (rst)
        set_hw[1] |=> ovf_flag[1]);
endmodule

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;
    logic [1:0] ovf_ack = 2'b00;
    logic [1:0] ovf_flag;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";
    int    tick_div = 1;
    bit    toggle1 = 0;

    dual_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_lo[2], m_hi[2], m_prev[2], m_run[2], m_flag[2];
    int m_mode;
    int fld, md, p, v, sp, sm[2], sh, setf[2], ev[2];

    always @(posedge clk) begin
        if (rst) begin
            for (int u = 0; u < 2; u++) begin
                m_lo[u] = 0; m_hi[u] = 0; m_prev[u] = 0; m_run[u] = 0; m_flag[u] = 0;
            end
            m_mode = 0;
        end else begin
            for (int u = 0; u < 2; u++) begin
                fld = (m_mode >> (4*u)) & 15;
                ev[u] = 0;
                if (tick && m_run[u] == 1 && (((fld >> 3) & 1) == 0 || gate_pin[u])) begin
                    if (((fld >> 2) & 1) == 1) ev[u] = (m_prev[u] == 1 && cnt_pin[u] == 0);
                    else ev[u] = 1;
                end
                if (tick) m_prev[u] = cnt_pin[u];
            end
            sp = ((m_mode & 3) == 3);
            sh = 0;
            for (int u = 0; u < 2; u++) begin
                md = (m_mode >> (4*u)) & 3;
                sm[u] = 0;
                if (ev[u]) begin
                    if (md == 0) begin
                        p = (m_lo[u] % 32) + 1;
                        if (p == 32) begin
                            p = 0; m_hi[u] = m_hi[u] + 1;
                            if (m_hi[u] == 256) begin m_hi[u] = 0; sm[u] = 1; end
                        end
                        m_lo[u] = (m_lo[u] / 32) * 32 + p;
                    end else if (md == 1) begin
                        v = m_hi[u] * 256 + m_lo[u] + 1;
                        if (v == 65536) begin v = 0; sm[u] = 1; end
                        m_hi[u] = v / 256; m_lo[u] = v % 256;
                    end else if (md == 2) begin
                        if (m_lo[u] == 255) begin m_lo[u] = m_hi[u]; sm[u] = 1; end
                        else m_lo[u] = m_lo[u] + 1;
                    end else if (u == 0) begin
                        m_lo[0] = m_lo[0] + 1;
                        if (m_lo[0] == 256) begin m_lo[0] = 0; sm[0] = 1; end
                    end
                end
            end
            if (sp && tick && m_run[1] == 1) begin
                m_hi[0] = m_hi[0] + 1;
                if (m_hi[0] == 256) begin m_hi[0] = 0; sh = 1; end
            end
            setf[0] = sm[0];
            setf[1] = sp ? sh : sm[1];
            for (int u = 0; u < 2; u++) begin
                if (setf[u]) m_flag[u] = 1;
                else if (wr_en && wr_sel == 1) m_flag[u] = (wr_data >> (5 + 2*u)) & 1;
                else if (ovf_ack[u]) m_flag[u] = 0;
            end
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_mode = wr_data;
                    3'd1: begin m_run[0] = wr_data[4]; m_run[1] = wr_data[6]; end
                    3'd2: m_lo[0] = wr_data;
                    3'd3: m_hi[0] = wr_data;
                    3'd4: m_lo[1] = wr_data;
                    3'd5: m_hi[1] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic int expect_of(input int s);
        case (s)
            0: return m_mode;
            1: return m_flag[1]*128 + m_run[1]*64 + m_flag[0]*32 + m_run[0]*16;
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    // compare every register and both flags once per clock, away from the edge
    always @(negedge clk) begin
        for (int s = 0; s < 7; s++) begin
            rd_sel = 3'(s);
            #1;
            n_chk++;
            if (int'(rd_data) != expect_of(s)) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", tag, s, rd_data, expect_of(s));
            end
        end
        n_chk++;
        if (ovf_flag != 2'(m_flag[1]*2 + m_flag[0])) begin
            n_bad++;
            $display("FAIL %s flags actual=%b expected=%0d%0d", tag, ovf_flag, m_flag[1], m_flag[0]);
        end
    end

    int kk = 0;
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 0; ovf_ack = 2'b00;
            kk++;
            tick = (tick_div <= 1) || (kk % tick_div == 0);
            if (toggle1) cnt_pin[1] = ~cnt_pin[1];
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input logic t = 1'b0);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = s; wr_data = d; ovf_ack = 2'b00; tick = t;
    endtask

    task automatic ack(input logic [1:0] m, input logic t = 1'b0);
        @(posedge clk); #1;
        wr_en = 0; ovf_ack = m; tick = t;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1 reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cyc(2);
        // R2 register map: lower control nibble ignored, unused selects read zero
        tag = "R2";
        wr(3'd1, 8'h0F); cyc(1);
        wr(3'd0, 8'hA5); cyc(1);
        wr(3'd6, 8'hFF); cyc(1);
        wr(3'd0, 8'h00); cyc(1);
        // R3 16-bit wrap
        tag = "R3";
        wr(3'd0, 8'h01); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
        cyc(8);
        // R10 flag clear/set paths and overflow priority
        tag = "R10";
        ack(2'b01); cyc(1);
        wr(3'd1, 8'h20); cyc(1);
        wr(3'd1, 8'h10); cyc(1);
        wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
        ack(2'b01, 1'b1); cyc(2);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd1, 8'h10, 1'b1); cyc(2);
        // R4 13-bit prescaled counting, upper low-byte bits held
        tag = "R4";
        wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd4, 8'hFD); wr(3'd5, 8'hFF);
        wr(3'd1, 8'h40);
        tick_div = 2; cyc(80);
        // R5 8-bit auto-reload
        tag = "R5";
        wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd2, 8'hFE); wr(3'd3, 8'hF0);
        ack(2'b11); wr(3'd1, 8'h10);
        tick_div = 1; cyc(40);
        // R8 gating by pin
        tag = "R8";
        wr(3'd0, 8'h0A); gate_pin = 2'b00; cyc(5);
        gate_pin[0] = 1'b1; cyc(5);
        wr(3'd1, 8'h00); cyc(3);
        gate_pin = 2'b00;
        // R9 external falling-edge counting
        tag = "R9";
        wr(3'd0, 8'h50); wr(3'd4, 8'hF0); wr(3'd5, 8'hFF); ack(2'b11); wr(3'd1, 8'h40);
        toggle1 = 1; cyc(40);
        toggle1 = 0; cyc(5);
        tick_div = 3; toggle1 = 1; cyc(30);
        toggle1 = 0; tick_div = 1;
        // R6 split mode on unit 0
        tag = "R6";
        wr(3'd1, 8'h00); wr(3'd0, 8'h13);
        wr(3'd2, 8'hFD); wr(3'd3, 8'hF8); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
        ack(2'b11); wr(3'd1, 8'h50);
        cyc(20);
        wr(3'd1, 8'h10); cyc(5);
        // R7 unit 1 halted in mode 11
        tag = "R7";
        wr(3'd0, 8'h30); wr(3'd1, 8'h50); cyc(6);
        // R11 byte write during a count event
        tag = "R11";
        wr(3'd0, 8'h01); wr(3'd1, 8'h10); cyc(2);
        wr(3'd2, 8'h55, 1'b1); cyc(2);
        wr(3'd3, 8'hAA, 1'b1); cyc(3);
        summary();
    end
endmodule